// File: doc/BRIEF.md
# Display Identification Block Reader

This block is a fixed-sequence, read-only I2C master that fetches one block of display identification data from a sink over the display data channel. Software loads a clock divider, a segment number and a half-segment selector through a small byte-wide register window. It then sets a start bit. The engine drives the whole bus conversation by itself and stores the returned bytes in an internal buffer. When it is done it flags completion, or an error if the sink refused an address byte.

When the segment number is non-zero, the engine first writes that number to the segment device (7-bit address 0x30). It then writes the byte offset (0x00 or 0x80) to the data device (7-bit address 0x50), issues a repeated start, reads the block, and finishes with a stop. A segment of zero skips the segment write completely. Software drains the buffer through one data register: each read returns the next byte.

A bit period is four divider quarters: SCL is low for two quarters and high for two. The divider is therefore (reference clock / 4) / SCL rate.

Top module: `edid_ddc_reader`

## Requirements
- R1: After reset, and whenever no transfer is running, SCL and SDA are both released (1). irq is 0, status (register 5) reads 0 and the busy bit (register 4, bit 0) reads 0.
- R2: The quarter length D is {register 1, register 0}, with 0 treated as 1. During a transfer every SCL low pulse and every SCL high pulse lasts exactly 2*D clock cycles.
- R3: SDA never changes in the same cycle as SCL. SDA changes while SCL is high only to form a START (falling) or a STOP (rising).
- R4: With segment (register 2) equal to zero, the bytes written on the bus are 0xA0, offset, 0xA1. With a non-zero segment they are 0x60, segment, 0xA0, offset, 0xA1. A repeated START precedes 0xA0 and 0xA1.
- R5: Only bit 7 of the word register (register 3) is kept, so it reads back as 0x00 or 0x80. That value is the offset sent to the sink.
- R6: BLOCK_BYTES bytes are read. Every byte is acknowledged except the last, which gets a NACK. A single STOP follows.
- R7: Status bit 0 (ready) becomes 1 only after the whole block is stored and the engine is idle again. irq shows ready only when mask bit 0 (register 6) is 1.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: Each read of register 7 returns the next stored byte in bus order, wrapping after BLOCK_BYTES. A start resets the read position to the first byte.
- R10: A NACK on any written byte aborts the transfer with a STOP. It sets status bit 1 (error) instead of ready. irq shows the error only when mask bit 1 is 1.
- R11: While busy, a start request and writes to the divider, segment and word registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register select (0 div low, 1 div high, 2 segment, 3 word, 4 control/busy, 5 status, 6 mask, 7 data) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (advances the data pointer at address 7) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Masked ready/error interrupt, active high |
| scl_out | output | 1 | SCL output, 1 = released |
| sda_out | output | 1 | SDA output, 1 = released |
| sda_in | input | 1 | SDA line as seen on the bus |

## Verification
The bench builds the engine with BLOCK_BYTES = 16. This makes full transfers short enough to run several of them, including the read pointer wrap and a restart in the middle of draining. Most runs use a quarter of 2 cycles. One aborting run uses a divider of 256, set only through the high byte, to show that both divider bytes take effect and that pulse widths scale with them. A behavioural sink answers with bytes computed from segment and offset, and can refuse any chosen byte to force the abort path.

// File: rtl/edid_ddc_reader.sv
module edid_ddc_reader #(
  parameter int BLOCK_BYTES = 128,
  parameter logic [6:0] SEG_DEV = 7'h30,
  parameter logic [6:0] DATA_DEV = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_out,
  output logic       sda_out,
  input  logic       sda_in
);
  localparam int PTR_W = $clog2(BLOCK_BYTES);
  localparam int CNT_W = $clog2(BLOCK_BYTES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TX, ST_RX, ST_STOP} state_t;

  state_t st;
  logic [7:0] div_lo, div_hi, seg_ptr;
  logic word_hi, sts_rdy, sts_err, msk_rdy, msk_err;
  logic [PTR_W-1:0] rd_ptr;
  logic [7:0] mem [BLOCK_BYTES];
  logic [15:0] qcnt, div_eff;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [2:0] stage;
  logic [CNT_W-1:0] rx_cnt;
  logic [7:0] shreg, cur_byte;
  logic samp, last_sda, aborted, sym_q1, sym_q3;

  wire busy = (st != ST_IDLE);
  wire tick = (qcnt == div_eff - 16'd1);
  wire sym_end = tick && (q == 2'd3);
  wire go = reg_we && (reg_addr == 3'd4) && reg_wdata[0] && !busy;
  wire pop = reg_re && (reg_addr == 3'd7);
  wire last_rx = (rx_cnt == CNT_W'(BLOCK_BYTES - 1));
  wire done_ok = (st == ST_STOP) && sym_end && !aborted;
  wire done_err = (st == ST_STOP) && sym_end && aborted;
  wire blk_full = (rx_cnt == CNT_W'(BLOCK_BYTES));
  wire rx_none = (rx_cnt == '0);

  assign div_eff = ({div_hi, div_lo} == 16'd0) ? 16'd1 : {div_hi, div_lo};

  always_comb begin
    case (stage)
      3'd0:    cur_byte = {SEG_DEV, 1'b0};
      3'd1:    cur_byte = seg_ptr;
      3'd2:    cur_byte = {DATA_DEV, 1'b0};
      3'd3:    cur_byte = {word_hi, 7'd0};
      default: cur_byte = {DATA_DEV, 1'b1};
    endcase
  end

  always_comb begin
    case (st)
      ST_START: sym_q1 = 1'b1;
      ST_STOP:  sym_q1 = 1'b0;
      ST_TX:    sym_q1 = bitn[3] ? 1'b1 : cur_byte[~bitn[2:0]];
      ST_RX:    sym_q1 = bitn[3] ? last_rx : 1'b1;
      default:  sym_q1 = 1'b1;
    endcase
    sym_q3 = (st == ST_START) ? 1'b0 : (st == ST_STOP) ? 1'b1 : sym_q1;
  end

  assign scl_out = !busy || q[1];
  assign sda_out = !busy ? 1'b1 : (q == 2'd0) ? last_sda : (q == 2'd3) ? sym_q3 : sym_q1;
  assign irq = (sts_rdy && msk_rdy) || (sts_err && msk_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      qcnt <= '0;
      q <= '0;
      bitn <= '0;
      stage <= '0;
      rx_cnt <= '0;
      shreg <= '0;
      samp <= 1'b1;
      last_sda <= 1'b1;
      aborted <= 1'b0;
    end else if (!busy) begin
      qcnt <= '0;
      q <= '0;
      if (go) begin
        st <= ST_START;
        stage <= (seg_ptr == 8'd0) ? 3'd2 : 3'd0;
        aborted <= 1'b0;
        rx_cnt <= '0;
        bitn <= '0;
      end
    end else begin
      qcnt <= tick ? 16'd0 : qcnt + 16'd1;
      if (tick) begin
        q <= q + 2'd1;
        if (q == 2'd2) begin
          samp <= sda_in;
          if (st == ST_RX && !bitn[3]) shreg <= {shreg[6:0], sda_in};
        end
        if (q == 2'd3) begin
          last_sda <= sym_q3;
          case (st)
            ST_START: begin
              st <= ST_TX;
              bitn <= '0;
            end
            ST_TX: begin
              if (!bitn[3]) bitn <= bitn + 4'd1;
              else if (samp) begin
                aborted <= 1'b1;
                st <= ST_STOP;
              end else begin
                bitn <= '0;
                case (stage)
                  3'd0: stage <= 3'd1;
                  3'd1: begin stage <= 3'd2; st <= ST_START; end
                  3'd2: stage <= 3'd3;
                  3'd3: begin stage <= 3'd4; st <= ST_START; end
                  default: st <= ST_RX;
                endcase
              end
            end
            ST_RX: begin
              if (!bitn[3]) bitn <= bitn + 4'd1;
              else begin
                bitn <= '0;
                rx_cnt <= rx_cnt + {{(CNT_W-1){1'b0}}, 1'b1};
                if (last_rx) st <= ST_STOP;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_RX && sym_end && bitn[3]) mem[rx_cnt[PTR_W-1:0]] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo <= '0;
      div_hi <= '0;
      seg_ptr <= '0;
      word_hi <= 1'b0;
      msk_rdy <= 1'b0;
      msk_err <= 1'b0;
      sts_rdy <= 1'b0;
      sts_err <= 1'b0;
      rd_ptr <= '0;
    end else begin
      if (reg_we && !busy) begin
        case (reg_addr)
          3'd0: div_lo <= reg_wdata;
          3'd1: div_hi <= reg_wdata;
          3'd2: seg_ptr <= reg_wdata;
          3'd3: word_hi <= reg_wdata[7];
          default: ;
        endcase
      end
      if (reg_we && reg_addr == 3'd6) begin
        msk_rdy <= reg_wdata[0];
        msk_err <= reg_wdata[1];
      end
      if (done_ok) sts_rdy <= 1'b1;
      else if (reg_we && reg_addr == 3'd5 && reg_wdata[0]) sts_rdy <= 1'b0;
      if (done_err) sts_err <= 1'b1;
      else if (reg_we && reg_addr == 3'd5 && reg_wdata[1]) sts_err <= 1'b0;
      if (go) rd_ptr <= '0;
      else if (pop) rd_ptr <= (rd_ptr == PTR_W'(BLOCK_BYTES - 1)) ? '0 : rd_ptr + {{(PTR_W-1){1'b0}}, 1'b1};
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = div_lo;
      3'd1: reg_rdata = div_hi;
      3'd2: reg_rdata = seg_ptr;
      3'd3: reg_rdata = {word_hi, 7'd0};
      3'd4: reg_rdata = {7'd0, busy};
      3'd5: reg_rdata = {6'd0, sts_err, sts_rdy};
      3'd6: reg_rdata = {6'd0, msk_err, msk_rdy};
      default: reg_rdata = mem[rd_ptr];
    endcase
  end
endmodule

// File: rtl/edid_ddc_reader_chk.sv
module edid_ddc_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_out,
  input logic sda_out,
  input logic busy,
  input logic sts_rdy,
  input logic sts_err,
  input logic blk_full,
  input logic rx_none
);
  AST_LINES_APART: assert property (@(posedge clk) disable iff (!rst_n) !$stable(scl_out) |-> $stable(sda_out)); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (scl_out && sda_out)); // R1
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(sts_rdy) |-> blk_full); // R7
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(sts_rdy) || $rose(sts_err)) |-> !busy); // R7
  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(sts_err) |-> rx_none); // R10
endmodule

bind edid_ddc_reader edid_ddc_reader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_out(scl_out), .sda_out(sda_out), .busy(busy),
  .sts_rdy(sts_rdy), .sts_err(sts_err), .blk_full(blk_full), .rx_none(rx_none)
);

// File: tb/edid_ddc_reader_tb_top.sv
module edid_ddc_reader_tb_top;
  localparam int BLK = 16;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [2:0] reg_addr = 0;
  logic reg_we = 0, reg_re = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, scl_out, sda_out, sda_in;
  logic drv = 0;
  assign sda_in = sda_out & ~drv;

  edid_ddc_reader #(.BLOCK_BYTES(BLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_out(scl_out),
    .sda_out(sda_out), .sda_in(sda_in)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] edid(input int s, input int i);
    return 8'((s * 37 + i * 5 + 3) & 255);
  endfunction

  // behavioural sink and bus monitor
  logic prev_scl = 1, prev_sda = 1, prev_sdao = 1;
  int bitc = 0, byte_idx = 0, seg_reg = 0, ptr = 0, stops = 0, clash = 0;
  int lowrun = 0, highrun = 0, nack_byte = -1;
  bit active = 0, rd_mode = 0, seen_low = 0;
  logic [7:0] in_byte = 0, cur_dev = 0, dnow;
  logic [7:0] wlog[$];
  bit acks[$];
  int lows[$], highs[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_out != prev_scl && sda_out != prev_sdao) clash++;
      if (!scl_out) lowrun++; else highrun++;
      if (scl_out && !prev_scl) begin lows.push_back(lowrun); lowrun = 0; seen_low = 1; end
      if (!scl_out && prev_scl) begin if (seen_low) highs.push_back(highrun); highrun = 0; end
      if (scl_out && prev_scl && prev_sda && !sda_in) begin
        active = 1; rd_mode = 0; bitc = 0; byte_idx = 0; in_byte = 0;
      end else if (scl_out && prev_scl && !prev_sda && sda_in) begin
        stops++; active = 0; rd_mode = 0; seg_reg = 0; drv = 0;
      end else if (scl_out && !prev_scl && active) begin
        if (!rd_mode && bitc < 8) in_byte = {in_byte[6:0], sda_in};
        if (rd_mode && bitc == 8) acks.push_back(!sda_in);
        bitc++;
      end else if (!scl_out && prev_scl && active) begin
        if (!rd_mode) begin
          if (bitc == 8) begin
            wlog.push_back(in_byte);
            if (int'(in_byte) == nack_byte) begin drv = 0; active = 0; end
            else begin
              drv = 1;
              if (byte_idx == 0) cur_dev = in_byte;
              else if (cur_dev == 8'h60) seg_reg = in_byte;
              else if (cur_dev == 8'hA0) ptr = in_byte;
              byte_idx++;
            end
          end else if (bitc == 9) begin
            drv = 0; bitc = 0; in_byte = 0;
            if (cur_dev == 8'hA1) begin rd_mode = 1; dnow = edid(seg_reg, ptr); drv = !dnow[7]; end
          end
        end else begin
          dnow = edid(seg_reg, ptr);
          if (bitc < 8) drv = !dnow[3'(7 - bitc)];
          else if (bitc == 8) drv = 0;
          else begin
            bitc = 0; ptr++;
            dnow = edid(seg_reg, ptr);
            if (acks[acks.size()-1]) drv = !dnow[7];
            else begin drv = 0; active = 0; end
          end
        end
      end
      prev_scl = scl_out; prev_sda = sda_in; prev_sdao = sda_out;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 3'(a); reg_wdata = 8'(d); reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 3'(a); reg_re = 1; #1 d = int'(reg_rdata);
    @(negedge clk); reg_re = 0;
  endtask
  task automatic clear_logs();
    @(negedge clk); #1;
    wlog.delete(); acks.delete(); lows.delete(); highs.delete();
    stops = 0; clash = 0; seen_low = 0; lowrun = 0;
  endtask
  task automatic wait_idle();
    int b;
    do rd(4, b); while (b[0]);
  endtask
  task automatic check_pulses(input int d, input string req);
    int bad = 0;
    foreach (lows[i]) if (lows[i] != 2 * d) bad++;
    foreach (highs[i]) if (highs[i] != 2 * d) bad++;
    chk(bad == 0 && lows.size() > 0, req, bad, 0);
  endtask
  task automatic check_wlog(input logic [7:0] e[$], input string req);
    bit ok = (wlog.size() == e.size());
    foreach (e[i]) if (ok && wlog[i] != e[i]) ok = 0;
    chk(ok, req, wlog.size(), e.size());
  endtask

  initial begin
    int v;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(scl_out && sda_out, "R1 lines released", {scl_out, sda_out}, 3);
    chk(irq == 0, "R1 irq", irq, 0);
    rd(5, v); chk(v == 0, "R1 status", v, 0);
    rd(4, v); chk(v == 0, "R1 busy", v, 0);

    wr(0, 2); wr(1, 0); wr(6, 0);
    wr(2, 0); wr(3, 0);
    clear_logs(); wr(4, 1); wait_idle();
    check_wlog('{8'hA0, 8'h00, 8'hA1}, "R4 seg zero sequence");
    check_pulses(2, "R2 quarter D=2");
    chk(clash == 0, "R3 sda vs scl", clash, 0);
    ok = (acks.size() == BLK);
    foreach (acks[i]) if (acks[i] != (i != BLK - 1)) ok = 0;
    chk(ok, "R6 ack pattern", acks.size(), BLK);
    chk(stops == 1, "R6 single stop", stops, 1);
    rd(5, v); chk(v == 1, "R7 ready set", v, 1);
    chk(irq == 0, "R7 irq masked", irq, 0);
    ok = 1;
    for (int i = 0; i < BLK; i++) begin rd(7, v); if (v != int'(edid(0, i))) ok = 0; end
    chk(ok, "R9 data order seg0", v, int'(edid(0, BLK - 1)));
    rd(7, v); chk(v == int'(edid(0, 0)), "R9 pointer wrap", v, int'(edid(0, 0)));

    wr(6, 1); @(negedge clk); chk(irq == 1, "R7 irq unmasked", irq, 1);
    wr(5, 0); rd(5, v); chk(v == 1, "R8 write 0 keeps", v, 1);
    wr(5, 1); rd(5, v); chk(v == 0, "R8 write 1 clears", v, 0);
    chk(irq == 0, "R8 irq drops", irq, 0);

    wr(2, 3); wr(3, 8'hFF);
    rd(3, v); chk(v == 8'h80, "R5 word readback", v, 8'h80);
    clear_logs(); wr(4, 1); wait_idle();
    check_wlog('{8'h60, 8'h03, 8'hA0, 8'h80, 8'hA1}, "R4 R5 segment sequence");
    chk(clash == 0, "R3 sda vs scl seg", clash, 0);
    ok = 1;
    for (int i = 0; i < 5; i++) begin rd(7, v); if (v != int'(edid(3, 128 + i))) ok = 0; end
    chk(ok, "R5 upper half data", v, int'(edid(3, 132)));

    clear_logs(); wr(4, 1);
    repeat (40) @(negedge clk);
    wr(2, 7); wr(0, 9); wr(4, 1);
    wait_idle();
    check_wlog('{8'h60, 8'h03, 8'hA0, 8'h80, 8'hA1}, "R11 start while busy ignored");
    rd(2, v); chk(v == 3, "R11 segment write ignored", v, 3);
    check_pulses(2, "R11 divider write ignored");
    rd(7, v); chk(v == int'(edid(3, 128)), "R9 start resets pointer", v, int'(edid(3, 128)));

    wr(5, 3); wr(6, 2); wr(0, 0); wr(1, 1); wr(2, 0); wr(3, 0);
    nack_byte = 8'hA0;
    clear_logs(); wr(4, 1); wait_idle();
    rd(5, v); chk(v == 2, "R10 error not ready", v, 2);
    chk(irq == 1, "R10 error irq", irq, 1);
    chk(stops == 1, "R10 stop after abort", stops, 1);
    check_wlog('{8'hA0}, "R10 abort after address");
    check_pulses(256, "R2 divider high byte");

    wr(5, 2); wr(6, 0); wr(0, 2); wr(1, 0); wr(2, 5);
    nack_byte = 8'h60;
    clear_logs(); wr(4, 1); wait_idle();
    rd(5, v); chk(v == 2, "R10 segment refused", v, 2);
    check_wlog('{8'h60}, "R10 no further bytes");
    chk(irq == 0, "R10 error masked", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule